// File: doc/BRIEF.md
# PWM Fault Trip Controller

This block sits between a PWM generator and its output pins and guards them against external faults. It watches two active-low fault inputs. Each input can be enabled as a latched source, as a self-releasing source, or as both. While any enabled source holds a trip, each of the two PWM outputs is replaced by a configured action. The action can pass the PWM through, drive the output high, drive it low, or release the pin by dropping its output enable.

A latched trip stays active until software clears it. A self-releasing trip ends on its own at the first counter-zero strobe from the PWM time base after every enabled input has returned high, so the outputs resume on a period boundary. The block keeps a status flag for each trip type and one interrupt flag. A trip sets the interrupt flag only when the enable for its type is on. The interrupt flag stays set until software writes a one to its clear bit, so an interrupt that is left uncleared is raised only once.

Software uses a plain register port. It writes one word per cycle and reads combinationally. The block has no streaming data path, so there is no valid/ready handshake and no back-pressure. All pins are plain control or status.

Top module: `pwm_fault_guard`

## Requirements
- R1: After reset, the status register reads 0 and `irq` is low. Each PWM output equals its input, and both output enables are high.
- R2: Fault inputs pass through two synchroniser flops and then the trip register. An input that falls before clock edge k forces the outputs after edge k+2, and not after edge k+1.
- R3: The latched trip comes from inputs enabled in config bits [1:0] (bit i selects input i). It stays active after the input returns high and after counter-zero strobes. It ends only when a 1 is written to status bit 1.
- R4: The self-releasing trip comes from inputs enabled in config bits [3:2]. It stays active while any enabled input is low. It ends at the first clock edge with `ctr_zero` high on which no enabled input is low.
- R5: Status bit 2 is set by a self-releasing trip and stays set after the trip ends. It is cleared by writing a 1 to status bit 2.
- R6: An input enabled for neither trip type has no effect on the outputs, the flags or `irq`.
- R7: The output action for A is in config bits [5:4] and for B in config bits [7:6]. 00 passes the PWM through. 01 forces the output high. 10 forces it low. 11 drives 0 with the output enable low. The action is applied only while a trip is active.
- R8: Status bit 0 drives `irq`. A latched trip sets it when config bit 8 is 1, and a self-releasing trip sets it when config bit 9 is 1. It stays set until a 1 is written to status bit 0.
- R9: If a write-one-to-clear and an active trip source fall on the same cycle, the flag stays set.
- R10: Address 0 reads back the config register in bits [9:0]. Address 1 reads the status register: bit 0 is the interrupt flag, bit 1 the latched trip, bit 2 the self-releasing flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_n | input | 2 | Asynchronous active-low fault inputs |
| ctr_zero | input | 1 | Counter-zero strobe from the PWM time base |
| pwm_a_in | input | 1 | PWM A from the generator |
| pwm_b_in | input | 1 | PWM B from the generator |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| pwm_a_out | output | 1 | Guarded PWM A |
| pwm_a_oe | output | 1 | Output enable for PWM A |
| pwm_b_out | output | 1 | Guarded PWM B |
| pwm_b_oe | output | 1 | Output enable for PWM B |
| irq | output | 1 | Interrupt flag |

## Verification
The assertions check four things on every cycle:
- With no trip active, the outputs follow their inputs.
- A latched trip persists unless its clear bit is written.
- A self-releasing trip ends only on a counter-zero cycle.
- A rising interrupt always has an enabled cause, and an active latched source always wins over a clear.

The bench scenarios cover what a single-cycle property cannot show: the exact edge count of the synchroniser, each action encoding, and that unselected inputs are ignored. They also show the sequences that end in a clear, for example that the interrupt flag outlives the trip that set it.

// File: rtl/fg_pkg.sv
package fg_pkg;
  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_HIGH = 2'b01,
    ACT_LOW  = 2'b10,
    ACT_HIZ  = 2'b11
  } trip_act_e;

  localparam int CFG_ADDR  = 0;
  localparam int STAT_ADDR = 1;

  localparam int ST_INT = 0;
  localparam int ST_OS  = 1;
  localparam int ST_CBC = 2;
  localparam int ST_W   = 3;
endpackage

// File: rtl/fg_sync.sv
module fg_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_n,
  output logic [W-1:0] sync_n
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '1;
      sync_n <= '1;
    end else begin
      meta_q <= async_n;
      sync_n <= meta_q;
    end
  end
endmodule

// File: rtl/fg_trip_core.sv
module fg_trip_core #(
  parameter int NF = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] fault_act,
  input  logic [NF-1:0] os_en,
  input  logic [NF-1:0] cbc_en,
  input  logic          ie_os,
  input  logic          ie_cbc,
  input  logic          ctr_zero,
  input  logic          clr_os,
  input  logic          clr_cbc,
  input  logic          clr_int,
  output logic          os_hit,
  output logic          cbc_hit,
  output logic          os_trip,
  output logic          cbc_trip,
  output logic          cbc_flag,
  output logic          int_flag
);
  logic int_set;

  always_comb begin
    os_hit  = |(fault_act & os_en);
    cbc_hit = |(fault_act & cbc_en);
    int_set = (os_hit & ie_os) | (cbc_hit & ie_cbc);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      os_trip  <= 1'b0;
      cbc_trip <= 1'b0;
      cbc_flag <= 1'b0;
      int_flag <= 1'b0;
    end else begin
      os_trip  <= os_hit  | (os_trip  & ~clr_os);
      cbc_trip <= cbc_hit | (cbc_trip & ~ctr_zero);
      cbc_flag <= cbc_hit | (cbc_flag & ~clr_cbc);
      int_flag <= int_set | (int_flag & ~clr_int);
    end
  end
endmodule

// File: rtl/fg_action_mux.sv
module fg_action_mux
  import fg_pkg::*;
(
  input  trip_act_e act,
  input  logic      tripped,
  input  logic      pwm_in,
  output logic      pwm_out,
  output logic      pwm_oe
);
  always_comb begin
    pwm_out = pwm_in;
    pwm_oe  = 1'b1;
    if (tripped) begin
      case (act)
        ACT_HIGH: pwm_out = 1'b1;
        ACT_LOW:  pwm_out = 1'b0;
        ACT_HIZ: begin
          pwm_out = 1'b0;
          pwm_oe  = 1'b0;
        end
        default:  pwm_out = pwm_in;
      endcase
    end
  end
endmodule

// File: rtl/pwm_fault_guard.sv
module pwm_fault_guard
  import fg_pkg::*;
#(
  parameter int NF     = 2,
  parameter int ADDR_W = 2,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NF-1:0]     fault_n,
  input  logic              ctr_zero,
  input  logic              pwm_a_in,
  input  logic              pwm_b_in,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              pwm_a_out,
  output logic              pwm_a_oe,
  output logic              pwm_b_out,
  output logic              pwm_b_oe,
  output logic              irq
);
  localparam int OS_LO  = 0;
  localparam int CBC_LO = NF;
  localparam int ACTA   = 2 * NF;
  localparam int ACTB   = 2 * NF + 2;
  localparam int IE_OS  = 2 * NF + 4;
  localparam int IE_CBC = 2 * NF + 5;
  localparam int CFG_W  = 2 * NF + 6;
  localparam int NOUT   = 2;

  logic [CFG_W-1:0] cfg_q;
  logic [NF-1:0]    sync_n;
  logic             cfg_we, stat_we;
  logic             clr_os, clr_cbc, clr_int;
  logic             os_hit, cbc_hit, os_trip, cbc_trip, cbc_flag, int_flag;
  logic             tripped;
  trip_act_e        act      [NOUT];
  logic             pin_in   [NOUT];
  logic             pin_out  [NOUT];
  logic             pin_oe   [NOUT];

  assign cfg_we  = wr_en && (wr_addr == ADDR_W'(CFG_ADDR));
  assign stat_we = wr_en && (wr_addr == ADDR_W'(STAT_ADDR));
  assign clr_int = stat_we && wr_data[ST_INT];
  assign clr_os  = stat_we && wr_data[ST_OS];
  assign clr_cbc = stat_we && wr_data[ST_CBC];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else if (cfg_we) cfg_q <= wr_data[CFG_W-1:0];
  end

  fg_sync #(.W(NF)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_n (fault_n),
    .sync_n  (sync_n)
  );

  fg_trip_core #(.NF(NF)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .fault_act (~sync_n),
    .os_en     (cfg_q[OS_LO +: NF]),
    .cbc_en    (cfg_q[CBC_LO +: NF]),
    .ie_os     (cfg_q[IE_OS]),
    .ie_cbc    (cfg_q[IE_CBC]),
    .ctr_zero  (ctr_zero),
    .clr_os    (clr_os),
    .clr_cbc   (clr_cbc),
    .clr_int   (clr_int),
    .os_hit    (os_hit),
    .cbc_hit   (cbc_hit),
    .os_trip   (os_trip),
    .cbc_trip  (cbc_trip),
    .cbc_flag  (cbc_flag),
    .int_flag  (int_flag)
  );

  assign tripped   = os_trip | cbc_trip;
  assign act[0]    = trip_act_e'(cfg_q[ACTA +: 2]);
  assign act[1]    = trip_act_e'(cfg_q[ACTB +: 2]);
  assign pin_in[0] = pwm_a_in;
  assign pin_in[1] = pwm_b_in;

  for (genvar g = 0; g < NOUT; g++) begin : g_out
    fg_action_mux u_mux (
      .act     (act[g]),
      .tripped (tripped),
      .pwm_in  (pin_in[g]),
      .pwm_out (pin_out[g]),
      .pwm_oe  (pin_oe[g])
    );
  end

  assign pwm_a_out = pin_out[0];
  assign pwm_a_oe  = pin_oe[0];
  assign pwm_b_out = pin_out[1];
  assign pwm_b_oe  = pin_oe[1];
  assign irq       = int_flag;

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_W'(CFG_ADDR)) begin
      rd_data[CFG_W-1:0] = cfg_q;
    end else if (rd_addr == ADDR_W'(STAT_ADDR)) begin
      rd_data[ST_INT] = int_flag;
      rd_data[ST_OS]  = os_trip;
      rd_data[ST_CBC] = cbc_flag;
    end
  end
endmodule

// File: rtl/fg_guard_checker.sv
module fg_guard_checker (
  input logic clk,
  input logic rst_n,
  input logic os_hit,
  input logic cbc_hit,
  input logic os_trip,
  input logic cbc_trip,
  input logic clr_os,
  input logic ctr_zero,
  input logic ie_os,
  input logic ie_cbc,
  input logic irq,
  input logic pwm_a_in,
  input logic pwm_b_in,
  input logic pwm_a_out,
  input logic pwm_a_oe,
  input logic pwm_b_out,
  input logic pwm_b_oe
);
  assert_idle_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(os_trip || cbc_trip) |-> (pwm_a_out == pwm_a_in && pwm_a_oe &&
                                pwm_b_out == pwm_b_in && pwm_b_oe));

  assert_os_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (os_trip && !clr_os) |=> os_trip);

  assert_cbc_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cbc_trip && !ctr_zero) |=> cbc_trip);

  assert_irq_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past((ie_os && os_hit) || (ie_cbc && cbc_hit)));

  assert_trip_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    os_hit |=> os_trip);
endmodule

bind pwm_fault_guard fg_guard_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .os_hit    (os_hit),
  .cbc_hit   (cbc_hit),
  .os_trip   (os_trip),
  .cbc_trip  (cbc_trip),
  .clr_os    (clr_os),
  .ctr_zero  (ctr_zero),
  .ie_os     (cfg_q[IE_OS]),
  .ie_cbc    (cfg_q[IE_CBC]),
  .irq       (irq),
  .pwm_a_in  (pwm_a_in),
  .pwm_b_in  (pwm_b_in),
  .pwm_a_out (pwm_a_out),
  .pwm_a_oe  (pwm_a_oe),
  .pwm_b_out (pwm_b_out),
  .pwm_b_oe  (pwm_b_oe)
);

// File: tb/tb_pwm_fault_guard.sv
module tb_pwm_fault_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  fault_n = 2'b11;
  logic        ctr_zero = 1'b0;
  logic        pwm_a_in = 1'b0;
  logic        pwm_b_in = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        pwm_a_out, pwm_a_oe, pwm_b_out, pwm_b_oe, irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    string       tag;
    bit          is_rd;
    logic [15:0] exp;
  } item_t;
  item_t sb_q[$];

  always #10 clk = ~clk;

  pwm_fault_guard dut (
    .clk(clk), .rst_n(rst_n), .fault_n(fault_n), .ctr_zero(ctr_zero),
    .pwm_a_in(pwm_a_in), .pwm_b_in(pwm_b_in),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .pwm_a_out(pwm_a_out), .pwm_a_oe(pwm_a_oe),
    .pwm_b_out(pwm_b_out), .pwm_b_oe(pwm_b_oe), .irq(irq)
  );

  // monitor: pops expected items and compares against the live outputs
  initial begin
    forever begin
      item_t it;
      logic [15:0] act;
      wait (sb_q.size() != 0);
      it = sb_q.pop_front();
      act = it.is_rd ? rd_data : {11'd0, irq, pwm_a_out, pwm_a_oe, pwm_b_out, pwm_b_oe};
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // pins = {irq, a_out, a_oe, b_out, b_oe}
  task automatic exp_pins(input string tag, input logic [4:0] e);
    item_t it;
    it.tag = tag; it.is_rd = 1'b0; it.exp = {11'd0, e};
    sb_q.push_back(it);
    #1;
  endtask

  task automatic exp_rd(input string tag, input logic [1:0] a, input logic [15:0] e);
    item_t it;
    rd_addr = a;
    #1;
    it.tag = tag; it.is_rd = 1'b1; it.exp = e;
    sb_q.push_back(it);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step(1);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic zero_pulse();
    ctr_zero = 1'b1;
    step(1);
    ctr_zero = 1'b0;
  endtask

  initial begin
    step(2);
    rst_n = 1'b1;
    step(1);
    exp_pins("R1 reset pins", 5'b0_0_1_1_1);
    exp_rd("R1 reset status", 2'd1, 16'h0000);

    // latched on input 0, self-releasing on input 1, A high, B low, latched irq enabled
    wr(2'd0, 16'h0199);
    exp_rd("R10 config readback", 2'd0, 16'h0199);

    fault_n = 2'b10;
    step(2);
    exp_pins("R2 not yet forced after two edges", 5'b0_0_1_1_1);
    step(1);
    exp_pins("R2 R7 forced on third edge", 5'b1_1_1_0_1);
    exp_rd("R8 R3 status after latched trip", 2'd1, 16'h0003);

    fault_n = 2'b11;
    step(4);
    zero_pulse();
    exp_pins("R3 latched trip holds", 5'b1_1_1_0_1);
    wr(2'd1, 16'h0002);
    exp_pins("R3 R8 clear latched, irq stays", 5'b1_0_1_1_1);
    exp_rd("R3 status after clear", 2'd1, 16'h0001);
    wr(2'd1, 16'h0001);
    exp_pins("R8 irq cleared", 5'b0_0_1_1_1);

    fault_n = 2'b01;
    step(3);
    exp_pins("R4 R8 self-release trip, no irq", 5'b0_1_1_0_1);
    exp_rd("R5 flag set", 2'd1, 16'h0004);
    fault_n = 2'b11;
    step(3);
    exp_pins("R4 held until zero strobe", 5'b0_1_1_0_1);
    zero_pulse();
    exp_pins("R4 released on zero strobe", 5'b0_0_1_1_1);
    exp_rd("R5 flag outlives trip", 2'd1, 16'h0004);
    wr(2'd1, 16'h0004);
    exp_rd("R5 flag cleared", 2'd1, 16'h0000);

    fault_n = 2'b01;
    step(3);
    wr(2'd1, 16'h0004);
    exp_rd("R9 clear loses to active source", 2'd1, 16'h0004);
    zero_pulse();
    exp_pins("R4 zero strobe ignored while low", 5'b0_1_1_0_1);
    fault_n = 2'b11;
    step(3);
    zero_pulse();
    wr(2'd1, 16'h0004);

    wr(2'd0, 16'h0190);
    fault_n = 2'b00;
    step(4);
    exp_pins("R6 unselected inputs ignored", 5'b0_0_1_1_1);
    exp_rd("R6 status untouched", 2'd1, 16'h0000);
    fault_n = 2'b11;
    step(3);

    pwm_a_in = 1'b1; pwm_b_in = 1'b0;
    wr(2'd0, 16'h0033);
    exp_pins("R1 passthrough new levels", 5'b0_1_1_0_1);
    fault_n = 2'b10;
    step(3);
    exp_pins("R7 A released, B passes", 5'b0_0_0_0_1);
    wr(2'd0, 16'h0063);
    exp_pins("R7 A low, B high", 5'b0_0_1_1_1);
    wr(2'd1, 16'h0002);
    exp_rd("R9 latched clear loses, R8 no irq", 2'd1, 16'h0002);
    fault_n = 2'b11;
    step(3);
    wr(2'd1, 16'h0002);
    exp_pins("R3 cleared after release", 5'b0_1_1_0_1);

    wr(2'd0, 16'h0294);
    fault_n = 2'b10;
    step(3);
    exp_pins("R8 irq from self-release type", 5'b1_1_1_0_1);
    wr(2'd1, 16'h0001);
    exp_pins("R9 irq clear loses to active source", 5'b1_1_1_0_1);
    fault_n = 2'b11;
    step(3);
    zero_pulse();
    wr(2'd1, 16'h0007);
    exp_pins("R8 irq cleared at end", 5'b0_1_1_0_1);
    exp_rd("R10 final status", 2'd1, 16'h0000);

    wait (sb_q.size() == 0);
    #1;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule